// File: doc/BRIEF.md
# Edge-Triggered Reset Pulse Generator

This block makes a reset pulse from a reset request. The request may arrive without regard to the target clock. Only a low-to-high transition of the request starts a pulse. A request that stays high after its rising edge leaves downstream logic free to run, so holding a button or a stuck request line cannot keep the design in reset. The pulse asserts at once, with no wait for a clock edge. It then stays high for a fixed number of target-clock edges and falls only on a target-clock edge. This makes it safe to use directly as the active-high asynchronous reset of flip-flops in the target domain.

Internally, a flag flop is clocked by the request itself and set on its rising edge. A short chain of flops, preset while the flag is high, carries the release into the clock domain. A cycle timer in the clock domain counts the edges seen while the pulse is high and clears the flag once the minimum width is reached. A small register bank is included that uses the pulse as its asynchronous reset, so the effect of each pulse can be seen through ordinary reads and writes.

Top module: `edge_rst_pulser`

## Requirements
- R1: From power-up, with no rising edge on `rst_req_i`, `rst_pulse_o` stays low.
- R2: A rising edge on `rst_req_i` while `rst_pulse_o` is low drives `rst_pulse_o` high before any further edge of `clk_i`.
- R3: After asserting, `rst_pulse_o` stays high and falls at the rising clock edge numbered PULSE_CYCLES + RELEASE_STAGES, counting from the first clock edge after assertion.
- R4: Holding `rst_req_i` high after a pulse has ended produces no further pulse, and the bank keeps its contents.
- R5: A new pulse needs `rst_req_i` to go low and then rise again; that new rise behaves as in R2 and R3.
- R6: A rising edge on `rst_req_i` while `rst_pulse_o` is high neither lengthens nor restarts the pulse. This holds both before and after the width timer has expired.
- R7: While `rst_pulse_o` is high, bank register i reads (17*i + 5) mod 2^BANK_WIDTH, and writes are ignored.
- R8: While `rst_pulse_o` is low, a write with `bank_wr_en_i` high updates the addressed register at the clock edge. The read port returns the register at `bank_rd_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Target clock |
| rst_req_i | input | 1 | Reset request, asynchronous to `clk_i`; only its rising edge counts |
| rst_pulse_o | output | 1 | Active-high reset pulse: asserts asynchronously, releases on `clk_i` |
| bank_wr_en_i | input | 1 | Write strobe of the example bank |
| bank_wr_addr_i | input | clog2(BANK_REGS) | Write address of the example bank |
| bank_wr_data_i | input | BANK_WIDTH | Write data of the example bank |
| bank_rd_addr_i | input | clog2(BANK_REGS) | Read address of the example bank |
| bank_rd_data_o | output | BANK_WIDTH | Combinational read data of the example bank |

## Verification
The bench builds the block with PULSE_CYCLES = 3, RELEASE_STAGES = 2 and a bank of four 8-bit registers, so each pulse spans five clock edges. With these values the timer's counting phase and the release-drain phase are each long enough to land a repeat request edge inside either one, so both halves of R6 are reached. The four seed values are all different, which shows whether a read comes from a reset register or from a written one.

// File: rtl/erp_pkg.sv
package erp_pkg;

  // Bits needed to hold a count that runs from 0 up to limit.
  function automatic int erp_cnt_width(int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  // Value loaded into bank register idx while the reset pulse is high.
  function automatic logic [31:0] erp_seed_word(int idx);
    return 32'(17 * idx + 5);
  endfunction

endpackage

// File: rtl/erp_edge_flag.sv
module erp_edge_flag (
  input  logic req_i,
  input  logic clear_i,
  output logic flag_o
);

  logic flag_q;

  // Set by the request's own rising edge; the clear wins while it is active.
  always_ff @(posedge req_i or posedge clear_i) begin
    if (clear_i) flag_q <= 1'b0;
    else         flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/erp_release_sync.sv
module erp_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic flag_i,
  output logic pulse_o
);

  generate
    if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or posedge flag_i) begin
        if (flag_i) q <= 1'b1;
        else        q <= 1'b0;
      end
      assign pulse_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or posedge flag_i) begin
        if (flag_i) q <= '1;
        else        q <= {q[STAGES-2:0], 1'b0};
      end
      assign pulse_o = q[STAGES-1];
    end
  endgenerate

  // R3: the pulse may only fall after the flag was seen low at a clock edge
  a_r3_release_after_flag: assert property (@(posedge clk_i) disable iff (flag_i)
    $fell(pulse_o) |-> !$past(flag_i));

endmodule

// File: rtl/erp_width_timer.sv
module erp_width_timer import erp_pkg::*; #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic pulse_i,
  output logic clear_o
);

  localparam int CW = erp_cnt_width(PULSE_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt_q;

  // Held at zero while no pulse is out; counts edges of the pulse, then saturates.
  always_ff @(posedge clk_i or negedge pulse_i) begin
    if (!pulse_i)           cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign clear_o = (cnt_q == LIMIT);

endmodule

// File: rtl/erp_reg_bank.sv
module erp_reg_bank import erp_pkg::*; #(
  parameter int REGS  = 4,
  parameter int WIDTH = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    wr_en_i,
  input  logic [$clog2(REGS)-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]        wr_data_i,
  input  logic [$clog2(REGS)-1:0] rd_addr_i,
  output logic [WIDTH-1:0]        rd_data_o
);

  logic [WIDTH-1:0] mem_q [REGS];

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      for (int i = 0; i < REGS; i++) mem_q[i] <= WIDTH'(erp_seed_word(i));
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R7: a register read during reset shows its seed word
  a_r7_seed_in_reset: assert property (@(posedge clk_i)
    rst_i |-> (rd_data_o == WIDTH'(erp_seed_word(int'(rd_addr_i)))));

  // R8: a write made outside reset lands by the next edge
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !rst_i) |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/edge_rst_pulser.sv
module edge_rst_pulser #(
  parameter int PULSE_CYCLES   = 2,
  parameter int RELEASE_STAGES = 2,
  parameter int BANK_REGS      = 4,
  parameter int BANK_WIDTH     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_req_i,
  output logic                         rst_pulse_o,
  input  logic                         bank_wr_en_i,
  input  logic [$clog2(BANK_REGS)-1:0] bank_wr_addr_i,
  input  logic [BANK_WIDTH-1:0]        bank_wr_data_i,
  input  logic [$clog2(BANK_REGS)-1:0] bank_rd_addr_i,
  output logic [BANK_WIDTH-1:0]        bank_rd_data_o
);

  // Named internal events, visible to the assertions below
  logic edge_flag;
  logic flag_clear;

  erp_edge_flag u_flag (
    .req_i   (rst_req_i),
    .clear_i (flag_clear),
    .flag_o  (edge_flag)
  );

  erp_release_sync #(.STAGES(RELEASE_STAGES)) u_release (
    .clk_i   (clk_i),
    .flag_i  (edge_flag),
    .pulse_o (rst_pulse_o)
  );

  erp_width_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .pulse_i (rst_pulse_o),
    .clear_o (flag_clear)
  );

  erp_reg_bank #(.REGS(BANK_REGS), .WIDTH(BANK_WIDTH)) u_bank (
    .clk_i     (clk_i),
    .rst_i     (rst_pulse_o),
    .wr_en_i   (bank_wr_en_i),
    .wr_addr_i (bank_wr_addr_i),
    .wr_data_i (bank_wr_data_i),
    .rd_addr_i (bank_rd_addr_i),
    .rd_data_o (bank_rd_data_o)
  );

  // R6: the timer may only clear the flag while a pulse is out
  a_r6_clear_only_in_pulse: assert property (@(posedge clk_i)
    flag_clear |-> rst_pulse_o);

  // R3: until the timer expires, the flag keeps the pulse alive
  a_r3_flag_until_timer: assert property (@(posedge clk_i) disable iff (!rst_pulse_o)
    !flag_clear |-> edge_flag);

endmodule

// File: tb/sim_edge_rst_pulser.sv
`timescale 1ns/1ps
module sim_edge_rst_pulser;
  localparam int P  = 3;
  localparam int S  = 2;
  localparam int NR = 4;
  localparam int W  = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          req = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          rst_pulse;
  logic [W-1:0]  rd_data;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Reference model state
  bit ref_rst = 1'b0;
  int ref_left = 0;
  int ref_mem [NR];
  bit ref_valid = 1'b0;

  always #10 clk = ~clk;

  edge_rst_pulser #(.PULSE_CYCLES(P), .RELEASE_STAGES(S), .BANK_REGS(NR), .BANK_WIDTH(W)) u0 (
    .clk_i          (clk),
    .rst_req_i      (req),
    .rst_pulse_o    (rst_pulse),
    .bank_wr_en_i   (wr_en),
    .bank_wr_addr_i (wr_addr),
    .bank_wr_data_i (wr_data),
    .bank_rd_addr_i (rd_addr),
    .bank_rd_data_o (rd_data)
  );

  function automatic int seed(int i);
    int v;
    v = i * 17 + 5;
    return v % (1 << W);
  endfunction

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // Model advance on each clock edge
  always @(posedge clk) begin
    if (ref_rst) begin
      ref_left--;
      if (ref_left == 0) ref_rst = 1'b0;
    end else if (wr_en && ref_valid) begin
      ref_mem[wr_addr] = wr_data;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(tag, rst_pulse, ref_rst, "pulse level");
      if (ref_valid) check(tag, rd_data, ref_mem[rd_addr], "read data");
    end
  end

  task automatic raise_req();
    bit fresh;
    @(negedge clk);
    #5;
    req = 1'b1;
    fresh = !ref_rst;
    if (fresh) begin
      ref_rst = 1'b1;
      ref_left = P + S;
      for (int i = 0; i < NR; i++) ref_mem[i] = seed(i);
      ref_valid = 1'b1;
    end
    #1;
    if (fresh) check("R2", rst_pulse, 1, "assert before clock edge");
    else       check("R6", rst_pulse, 1, "pulse still high");
  endtask

  task automatic drop_req();
    @(negedge clk);
    #5;
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(int a, int d);
    @(negedge clk);
    #2;
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = W'(d);
    @(negedge clk);
    #2;
    wr_en = 1'b0;
  endtask

  task automatic sweep(string t);
    @(negedge clk);
    #2;
    for (int a = 0; a < NR; a++) begin
      rd_addr = AW'(a);
      #1;
      check(t, rd_data, ref_mem[a], "sweep read");
    end
  endtask

  initial begin
    // R1: idle after power-up
    tag = "R1";
    idle(6);
    check("R1", rst_pulse, 0, "no pulse without request");

    // R2, R3, R7: first pulse, seeds, write blocked during pulse
    tag = "R3";
    raise_req();
    sweep("R7");
    write_reg(1, 8'hAA);
    idle(6);
    sweep("R7");

    // R8: writes with the request still high
    tag = "R8";
    write_reg(0, 8'h3C);
    write_reg(2, 8'hC3);
    write_reg(3, 8'h81);
    sweep("R8");

    // R4: request kept high, nothing resets
    tag = "R4";
    idle(20);
    sweep("R4");
    check("R4", rst_pulse, 0, "no retrigger while held");

    // R5: low then high gives a new pulse
    tag = "R5";
    drop_req();
    idle(2);
    check("R5", rst_pulse, 0, "low request alone does nothing");
    raise_req();
    idle(8);
    sweep("R5");

    // R6: repeat edge during counting phase
    tag = "R6";
    write_reg(1, 8'h55);
    drop_req();
    raise_req();
    drop_req();
    raise_req();
    idle(8);
    sweep("R6");

    // R6: repeat edge during clear/drain phase
    write_reg(2, 8'h77);
    drop_req();
    raise_req();
    drop_req();
    idle(2);
    raise_req();
    idle(8);
    sweep("R6");
    check("R6", rst_pulse, 0, "pulse ended on time");

    // R5: rise right after a release starts a fresh pulse
    tag = "R5";
    write_reg(3, 8'h19);
    drop_req();
    raise_req();
    idle(8);
    sweep("R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule